// File: doc/BRIEF.md
# Serial Register-Access Bridge

This block is a serial-peripheral slave that lets an external host reach a 32-bit internal register space. The host sends one frame per access while chip select is low. The frame opens with a 24-bit address phase whose top bit marks a write. A write frame then carries 32 data bits, and the bridge presents one write on an internal request/ready port after the last bit. A read frame launches the internal read as soon as the address is complete. A programmable number of padding bytes follows, during which the input line is ignored, and then the bridge shifts the 32-bit result out.

The transmitted address is a word index. The internal byte address is that index times four. Two local registers sit in a small window at word indices `LOC_IDX` and `LOC_IDX+1` and are never forwarded to the internal port. The first selects the payload format, meaning byte order and bit order. The second holds the padding count, a sticky flag for read data that arrived too late, and a fixed interface code. The serial clock and chip select are brought into the system clock domain, and the system clock must run at least eight times faster than the serial clock. Mode 0 timing is used: the input is sampled on the rising serial clock edge, and the output changes after the falling edge.

Top module: `spi_reg_bridge`

## Requirements
- R1: The first 24 bits of a frame form the address, most significant bit first, in every payload format. Bit 23 is the write flag (1 = write, 0 = read). Bits 22:0 are a word index, and the internal request carries byte address `{index, 2'b00}`.
- R2: A write frame with an external index raises exactly one internal request with `reg_we`=1 after its 56th bit. Its `reg_wdata` is the 32 received payload bits decoded with the active format.
- R3: A read frame with an external index raises one internal request with `reg_we`=0 after its 24th bit. Then 8×pad padding bits are ignored, and the next 32 falling serial edges drive the payload on `miso`, encoded with the active format.
- R4: The payload format is a 2-bit code. Bit 0 selects byte order: 0 sends byte 0 (bits 7:0) first, and 1 sends byte 3 first. Bit 1 selects bit order within each byte: 0 sends bit 7 first, and 1 sends bit 0 first.
- R5: The control register at index `LOC_IDX` takes the format from bits 1:0 of the decoded write word. It reads back as each byte equal to `{f[0], f[1], 0000, f[1], f[0]}`, which decodes the same under every format. Only a write to it changes the format.
- R6: The status register at index `LOC_IDX+1` holds the padding count in bits 3:0. Bit 16 is the sticky too-late flag, and writing 1 to bit 16 clears it. Bits 31:24 read as 2, and all other bits read as 0.
- R7: If the internal read has not completed when the first payload bit must be driven, the bridge returns all zeros for that frame and sets the too-late flag.
- R8: Raising chip select before the 56th bit of a write frame aborts the frame. No internal request is made and no local register changes.
- R9: After reset the format is 00, the padding count is 0, the flag is clear, `miso` is 0 and `reg_req` is 0.
- R10: Accesses to the two local indices never raise `reg_req`.
- R11: Once raised, `reg_req` stays high with `reg_addr`, `reg_we` and `reg_wdata` stable until `reg_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| reg_req | output | 1 | Internal access request |
| reg_we | output | 1 | Internal access is a write |
| reg_addr | output | 25 | Internal byte address |
| reg_wdata | output | 32 | Internal write data |
| reg_rdata | input | 32 | Internal read data, valid with ready |
| reg_ready | input | 1 | Internal access complete |

## Verification
Random writes and reads to external indices are run under all four payload formats with non-zero padding and random responder latency. A wrong byte or bit mapping in the encode or decode paths, or a wrong address shift, shows up as a data or address miscompare. Directed frames cover the local registers, including the format-independent control pattern, the status layout and the write-one-to-clear flag. Further directed cases separate a read served too late (zero data and a set flag) from a normal read, and an aborted write from a completed one by checking the request count and the stored values.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef logic [1:0] fmt_t;

  // Map the k-th payload bit on the wire to its bit index in the word.
  function automatic logic [4:0] lane_bit(input logic [4:0] k, input fmt_t f);
    logic [1:0] slot;
    logic [2:0] pos;
    slot = f[0] ? ~k[4:3] : k[4:3];
    pos  = f[1] ? k[2:0] : ~k[2:0];
    return {slot, pos};
  endfunction

  function automatic logic [WORD_W-1:0] stream_to_word(input logic [WORD_W-1:0] s,
                                                       input fmt_t f);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < WORD_W; k++) begin
      w[lane_bit(5'(k), f)] = s[k];
    end
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_image(input fmt_t f);
    logic [BYTE_W-1:0] b;
    b = {f[0], f[1], 4'b0000, f[1], f[0]};
    return {4{b}};
  endfunction

endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync (
  input  logic clk,
  input  logic rst_ni,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic rise,
  output logic fall,
  output logic sel,
  output logic mosi_s
);
  logic [2:0] sclk_q, sclk_n;
  logic [1:0] cs_q, cs_n_n;
  logic [1:0] mosi_q, mosi_n;

  always_comb begin
    sclk_n = {sclk_q[1:0], sclk};
    cs_n_n = {cs_q[0], cs_n};
    mosi_n = {mosi_q[0], mosi};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 3'b000;
      cs_q   <= 2'b11;
      mosi_q <= 2'b00;
    end else begin
      sclk_q <= sclk_n;
      cs_q   <= cs_n_n;
      mosi_q <= mosi_n;
    end
  end

  assign rise   = sclk_q[1] & ~sclk_q[2];
  assign fall   = ~sclk_q[1] & sclk_q[2];
  assign sel    = ~cs_q[1];
  assign mosi_s = mosi_q[1];
endmodule

// File: rtl/spi_bridge_frame.sv
module spi_bridge_frame
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAD_W  = 4,
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              rise,
  input  logic              fall,
  input  logic              sel,
  input  logic              mosi_s,
  input  logic [PAD_W-1:0]  pad,
  input  fmt_t              fmt,
  input  logic              rd_ok,
  input  logic [WORD_W-1:0] rd_word,
  output logic              miso,
  output logic              launch_rd,
  output logic              launch_wr,
  output logic [IDX_W-1:0]  launch_idx,
  output logic [WORD_W-1:0] launch_wdata,
  output logic              too_late
);
  localparam int MAX_BITS = ADDR_W + BYTE_W * ((1 << PAD_W) - 1) + WORD_W;
  localparam int CNT_W    = $clog2(MAX_BITS + 2);
  localparam logic [CNT_W-1:0] C_ADDR = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_WORD = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] C_WLST = CNT_W'(ADDR_W + WORD_W - 1);
  localparam logic [CNT_W-1:0] C_MAX  = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [WORD_W-1:0] din_q, din_n;
  logic [WORD_W-1:0] dword_q, dword_n;
  logic              miso_q, miso_n;
  logic              rdf_q, rdf_n;

  logic [CNT_W-1:0]  d0, rel_rd, rel_wr;
  logic [WORD_W-1:0] word;

  assign d0     = C_ADDR + CNT_W'({pad, 3'b000});
  assign rel_rd = cnt_q - d0;
  assign rel_wr = cnt_q - C_ADDR;

  always_comb begin
    cnt_n     = cnt_q;
    addr_n    = addr_q;
    din_n     = din_q;
    dword_n   = dword_q;
    miso_n    = miso_q;
    rdf_n     = rdf_q;
    launch_rd = 1'b0;
    launch_wr = 1'b0;
    too_late  = 1'b0;
    word      = dword_q;
    if (!sel) begin
      cnt_n  = '0;
      miso_n = 1'b0;
      rdf_n  = 1'b0;
    end else if (rise) begin
      if (cnt_q != C_MAX) cnt_n = cnt_q + 1'b1;
      if (cnt_q < C_ADDR) addr_n = {addr_q[ADDR_W-2:0], mosi_s};
      if (cnt_q == C_ADDR - 1'b1 && !addr_q[ADDR_W-2]) begin
        launch_rd = 1'b1;
        rdf_n     = 1'b1;
      end
      if (addr_q[ADDR_W-1] && cnt_q >= C_ADDR && cnt_q <= C_WLST) begin
        din_n[rel_wr[4:0]] = mosi_s;
        if (cnt_q == C_WLST) launch_wr = 1'b1;
      end
    end else if (fall && rdf_q && cnt_q >= d0 && cnt_q < d0 + C_WORD) begin
      if (rel_rd[4:0] == 5'd0) begin
        word     = rd_ok ? rd_word : '0;
        too_late = ~rd_ok;
        dword_n  = word;
      end
      miso_n = word[lane_bit(rel_rd[4:0], fmt)];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      addr_q  <= '0;
      din_q   <= '0;
      dword_q <= '0;
      miso_q  <= 1'b0;
      rdf_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      addr_q  <= addr_n;
      din_q   <= din_n;
      dword_q <= dword_n;
      miso_q  <= miso_n;
      rdf_q   <= rdf_n;
    end
  end

  assign miso         = miso_q;
  assign launch_idx   = launch_rd ? {addr_q[ADDR_W-3:0], mosi_s} : addr_q[ADDR_W-2:0];
  assign launch_wdata = stream_to_word(din_n, fmt);
endmodule

// File: rtl/spi_bridge_regs.sv
module spi_bridge_regs
  import spi_bridge_pkg::*;
#(
  parameter int PAD_W = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_sel,
  input  logic              set_flag,
  output fmt_t              fmt,
  output logic [PAD_W-1:0]  pad,
  output logic              flag,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [7:0] IF_CODE  = 8'd2;
  localparam int         FLAG_BIT = 16;

  fmt_t             fmt_q, fmt_n;
  logic [PAD_W-1:0] pad_q, pad_n;
  logic             flag_q, flag_n;
  logic [WORD_W-1:0] stat;

  always_comb begin
    fmt_n  = fmt_q;
    pad_n  = pad_q;
    flag_n = flag_q;
    if (wr_en && !wr_sel) fmt_n = wdata[1:0];
    if (wr_en && wr_sel) begin
      pad_n = wdata[PAD_W-1:0];
      if (wdata[FLAG_BIT]) flag_n = 1'b0;
    end
    if (set_flag) flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= 2'b00;
      pad_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      fmt_q  <= fmt_n;
      pad_q  <= pad_n;
      flag_q <= flag_n;
    end
  end

  always_comb begin
    stat               = '0;
    stat[31:24]        = IF_CODE;
    stat[FLAG_BIT]     = flag_q;
    stat[PAD_W-1:0]    = pad_q;
  end

  assign rdata = rd_sel ? stat : ctrl_image(fmt_q);
  assign fmt   = fmt_q;
  assign pad   = pad_q;
  assign flag  = flag_q;
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAD_W  = 4,
  parameter logic [ADDR_W-2:0] LOC_IDX = 23'h700000,
  localparam int IDX_W = ADDR_W - 1,
  localparam int RA_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              reg_req,
  output logic              reg_we,
  output logic [RA_W-1:0]   reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] reg_rdata,
  input  logic              reg_ready
);
  logic [1:0] rst_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  logic              rise_w, fall_w, sel_w, mosi_w;
  logic              launch_rd_w, launch_wr_w, too_late_w;
  logic [IDX_W-1:0]  launch_idx_w;
  logic [WORD_W-1:0] launch_wdata_w, loc_rdata_w;
  fmt_t              fmt_w;
  logic [PAD_W-1:0]  pad_w;
  logic              flag_w, is_loc, loc_wr_w, ctrl_wr_w;

  logic              req_q, req_n, we_q, we_n;
  logic [IDX_W-1:0]  ridx_q, ridx_n, pidx_q, pidx_n;
  logic [WORD_W-1:0] rwd_q, rwd_n, pwd_q, pwd_n;
  logic              pend_q, pend_n, pwe_q, pwe_n;
  logic              want_q, want_n, rdv_q, rdv_n;
  logic [WORD_W-1:0] rdbuf_q, rdbuf_n;

  spi_bridge_sync u_sync (
    .clk(clk), .rst_ni(rst_ni), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .rise(rise_w), .fall(fall_w), .sel(sel_w), .mosi_s(mosi_w)
  );

  spi_bridge_frame #(.ADDR_W(ADDR_W), .PAD_W(PAD_W)) u_frame (
    .clk(clk), .rst_ni(rst_ni), .rise(rise_w), .fall(fall_w), .sel(sel_w),
    .mosi_s(mosi_w), .pad(pad_w), .fmt(fmt_w), .rd_ok(rdv_q), .rd_word(rdbuf_q),
    .miso(miso), .launch_rd(launch_rd_w), .launch_wr(launch_wr_w),
    .launch_idx(launch_idx_w), .launch_wdata(launch_wdata_w), .too_late(too_late_w)
  );

  assign is_loc    = (launch_idx_w[IDX_W-1:1] == LOC_IDX[IDX_W-1:1]);
  assign loc_wr_w  = launch_wr_w & is_loc;
  assign ctrl_wr_w = loc_wr_w & ~launch_idx_w[0];

  spi_bridge_regs #(.PAD_W(PAD_W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_en(loc_wr_w), .wr_sel(launch_idx_w[0]),
    .wdata(launch_wdata_w), .rd_sel(launch_idx_w[0]), .set_flag(too_late_w),
    .fmt(fmt_w), .pad(pad_w), .flag(flag_w), .rdata(loc_rdata_w)
  );

  always_comb begin
    req_n = req_q;  we_n = we_q;  ridx_n = ridx_q;  rwd_n = rwd_q;
    pend_n = pend_q; pwe_n = pwe_q; pidx_n = pidx_q; pwd_n = pwd_q;
    want_n = want_q; rdv_n = rdv_q; rdbuf_n = rdbuf_q;
    // internal port handshake
    if (req_q) begin
      if (reg_ready) begin
        req_n = 1'b0;
        if (!we_q && want_q) begin
          rdbuf_n = reg_rdata;
          rdv_n   = 1'b1;
        end
      end
    end else if (pend_q) begin
      req_n  = 1'b1;
      we_n   = pwe_q;
      ridx_n = pidx_q;
      rwd_n  = pwd_q;
      pend_n = 1'b0;
    end
    // frame end drops read state, keeps a queued write
    if (!sel_w) begin
      want_n = 1'b0;
      rdv_n  = 1'b0;
      if (pend_q && !pwe_q) pend_n = 1'b0;
    end
    // new accesses from the frame engine
    if (launch_rd_w) begin
      if (is_loc) begin
        rdbuf_n = loc_rdata_w;
        rdv_n   = 1'b1;
      end else begin
        pend_n = 1'b1;
        pwe_n  = 1'b0;
        pidx_n = launch_idx_w;
        want_n = 1'b1;
      end
    end
    if (launch_wr_w && !is_loc) begin
      pend_n = 1'b1;
      pwe_n  = 1'b1;
      pidx_n = launch_idx_w;
      pwd_n  = launch_wdata_w;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;  we_q <= 1'b0;  ridx_q <= '0;  rwd_q <= '0;
      pend_q <= 1'b0; pwe_q <= 1'b0; pidx_q <= '0;  pwd_q <= '0;
      want_q <= 1'b0; rdv_q <= 1'b0; rdbuf_q <= '0;
    end else begin
      req_q <= req_n;  we_q <= we_n;  ridx_q <= ridx_n;  rwd_q <= rwd_n;
      pend_q <= pend_n; pwe_q <= pwe_n; pidx_q <= pidx_n; pwd_q <= pwd_n;
      want_q <= want_n; rdv_q <= rdv_n; rdbuf_q <= rdbuf_n;
    end
  end

  assign reg_req   = req_q;
  assign reg_we    = we_q;
  assign reg_addr  = {ridx_q, 2'b00};
  assign reg_wdata = rwd_q;
endmodule

// File: rtl/spi_reg_bridge_chk.sv
module spi_reg_bridge_chk #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-2:0] LOC_IDX = 23'h700000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_req,
  input logic              reg_ready,
  input logic              reg_we,
  input logic [ADDR_W:0]   reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              miso,
  input logic              sel,
  input logic              too_late,
  input logic              flag,
  input logic [1:0]        fmt,
  input logic              ctrl_wr
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ready |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

  assert_no_local_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> reg_addr[ADDR_W:3] != LOC_IDX[ADDR_W-2:1]);

  assert_late_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    too_late |=> flag);

  assert_miso_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso);

  assert_fmt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(fmt));
endmodule

bind spi_reg_bridge spi_reg_bridge_chk #(.ADDR_W(ADDR_W), .LOC_IDX(LOC_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_ready(reg_ready), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .miso(miso), .sel(sel_w),
  .too_late(too_late_w), .flag(flag_w), .fmt(fmt_w), .ctrl_wr(ctrl_wr_w)
);

// File: tb/tb_spi_reg_bridge.sv
`timescale 1ns/1ps
module tb_spi_reg_bridge;
  localparam int HP = 6;
  localparam logic [22:0] LOC = 23'h700000;

  logic clk, rst_n, sclk, cs_n, mosi, miso;
  logic reg_req, reg_we, reg_ready;
  logic [24:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  spi_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ready(reg_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, req_cnt = 0, lat_next = 0;
  bit done = 0;
  logic [1:0] cur_fmt = 2'b00;
  int cur_pad = 0;
  logic [31:0] mem [64];
  logic [31:0] sh [64];
  logic        last_we;
  logic [24:0] last_addr;
  logic [31:0] last_wd;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int lane(input int k, input logic [1:0] f);
    int s, p;
    s = k / 8; p = k % 8;
    return 8 * (f[0] ? 3 - s : s) + (f[1] ? p : 7 - p);
  endfunction

  function automatic logic [31:0] sym(input logic [1:0] f);
    return {4{f[0], f[1], 4'b0000, f[1], f[0]}};
  endfunction

  function automatic logic [31:0] statv(input bit fl, input int p);
    return {8'd2, 7'd0, fl, 12'd0, 4'(p)};
  endfunction

  // internal register responder with variable latency
  initial begin
    bit seen; int cl, lat; logic [24:0] a0; logic [31:0] w0;
    seen = 0; cl = 0; lat = 0; a0 = '0; w0 = '0;
    reg_ready = 1'b0; reg_rdata = '0;
    forever begin
      @(negedge clk);
      if (reg_ready) reg_ready = 1'b0;
      else if (reg_req) begin
        if (!seen) begin seen = 1; a0 = reg_addr; w0 = reg_wdata; cl = 0; lat = lat_next; end
        if (cl >= lat) begin
          chk(reg_addr == a0 && reg_wdata == w0, "R11 request stable", {7'd0, reg_addr}, {7'd0, a0});
          reg_ready = 1'b1;
          req_cnt++;
          last_we = reg_we; last_addr = reg_addr; last_wd = reg_wdata;
          if (reg_we) mem[reg_addr[7:2]] = reg_wdata;
          else reg_rdata = mem[reg_addr[7:2]];
          seen = 0;
        end else cl++;
      end
    end
  end

  task automatic xfer(input bit we, input logic [22:0] idx, input logic [31:0] val,
                      input int stop_after, output logic [31:0] rd);
    int total, d0; logic [23:0] a; logic b;
    a = {we, idx}; d0 = 24 + 8 * cur_pad; total = we ? 56 : d0 + 32; rd = '0;
    cs_n = 1'b0;
    for (int n = 0; n < total; n++) begin
      if (n < 24) b = a[23 - n];
      else if (we) b = val[lane(n - 24, cur_fmt)];
      else b = 1'($urandom % 2);
      mosi = b;
      repeat (HP) @(negedge clk);
      if (!we && n >= d0) rd[lane(n - d0, cur_fmt)] = miso;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
      if (n + 1 == stop_after) break;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1; mosi = 1'b0;
    repeat (3 * HP) @(negedge clk);
  endtask

  task automatic set_fmt(input logic [1:0] f);
    logic [31:0] rd;
    xfer(1, LOC, sym(f), 0, rd);
    cur_fmt = f;
  endtask

  task automatic set_pad(input int p, input bit clr);
    logic [31:0] rd;
    xfer(1, LOC + 23'd1, {15'd0, clr, 12'd0, 4'(p)}, 0, rd);
    cur_pad = p;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, v; logic [22:0] idx; int rc;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 64; i++) begin v = $urandom; mem[i] = v; sh[i] = v; end
    sclk = 0; cs_n = 1; mosi = 0; rst_n = 0;
    repeat (5) @(negedge clk);
    chk(miso == 1'b0, "R9 miso after reset", {31'd0, miso}, 0);
    chk(reg_req == 1'b0, "R9 req after reset", {31'd0, reg_req}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R9 / R5 / R6 defaults; local reads with zero padding; R10 no request
    rc = req_cnt;
    xfer(0, LOC, 0, 0, rd);
    chk(rd == sym(2'b00), "R9 R5 default control", rd, sym(2'b00));
    xfer(0, LOC + 23'd1, 0, 0, rd);
    chk(rd == statv(0, 0), "R9 R6 default status", rd, statv(0, 0));
    set_pad(2, 0);
    xfer(0, LOC + 23'd1, 0, 0, rd);
    chk(rd == statv(0, 2), "R6 padding readback", rd, statv(0, 2));
    chk(req_cnt == rc, "R10 local access no request", req_cnt, rc);

    // random traffic in every format (R1 R2 R3 R4 R5)
    for (int f = 0; f < 4; f++) begin
      set_fmt(2'(f));
      set_pad(1 + int'($urandom % 3), 0);
      xfer(0, LOC, 0, 0, rd);
      chk(rd == sym(2'(f)), "R5 R4 control readback", rd, sym(2'(f)));
      for (int t = 0; t < 10; t++) begin
        idx = 23'($urandom % 64);
        lat_next = $urandom % 21;
        rc = req_cnt;
        if ($urandom % 2) begin
          v = $urandom;
          xfer(1, idx, v, 0, rd);
          repeat (40) @(negedge clk);
          sh[idx[5:0]] = v;
          chk(req_cnt == rc + 1 && last_we && last_addr == {idx, 2'b00},
              "R1 R2 write request", {7'd0, last_addr}, {7'd0, idx, 2'b00});
          chk(last_wd == v, "R2 R4 write data", last_wd, v);
        end else begin
          xfer(0, idx, 0, 0, rd);
          chk(req_cnt == rc + 1 && !last_we && last_addr == {idx, 2'b00},
              "R1 R3 read request", {7'd0, last_addr}, {7'd0, idx, 2'b00});
          chk(rd == sh[idx[5:0]], "R3 R4 read data", rd, sh[idx[5:0]]);
        end
      end
    end

    // R8 aborted external write
    lat_next = 0; rc = req_cnt; idx = 23'd5;
    xfer(1, idx, ~sh[5], 40, rd);
    repeat (40) @(negedge clk);
    chk(req_cnt == rc, "R8 abort no request", req_cnt, rc);
    xfer(0, idx, 0, 0, rd);
    chk(rd == sh[5], "R8 abort value kept", rd, sh[5]);
    // R8 aborted local write
    xfer(1, LOC + 23'd1, 32'h0000_0007, 50, rd);
    xfer(0, LOC + 23'd1, 0, 0, rd);
    chk(rd == statv(0, cur_pad), "R8 abort local unchanged", rd, statv(0, cur_pad));

    // R7 too-late read with zero padding
    set_pad(0, 0);
    lat_next = 40;
    xfer(0, 23'd9, 0, 0, rd);
    chk(rd == 32'd0, "R7 late read returns zero", rd, 0);
    repeat (60) @(negedge clk);
    lat_next = 0;
    xfer(0, LOC + 23'd1, 0, 0, rd);
    chk(rd == statv(1, 0), "R7 R6 flag set", rd, statv(1, 0));
    set_pad(1, 0);
    xfer(0, LOC + 23'd1, 0, 0, rd);
    chk(rd == statv(1, 1), "R6 flag sticky", rd, statv(1, 1));
    set_pad(1, 1);
    xfer(0, LOC + 23'd1, 0, 0, rd);
    chk(rd == statv(0, 1), "R6 flag cleared by write one", rd, statv(0, 1));
    lat_next = 3;
    xfer(0, 23'd9, 0, 0, rd);
    chk(rd == sh[9], "R3 read after flag clear", rd, sh[9]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule